// File: doc/BRIEF.md
# Flash Write-Completion Poller

After a host has sent a program or erase command to a parallel flash, this controller finds out when the internal write has finished. It repeatedly reads a status byte through a simple read request/response port and judges each reply with one of two methods. Complement polling watches the most significant data bit, and toggle detection watches the bit just below it. When a reply first looks complete, the poller does not stop. It reads the same location twice more and reports completion only if both extra replies also look complete. A status read that lands at the same moment the write ends can return a torn value, and these extra reads filter that out.

A start pulse, accepted only while the poller is idle, captures four values: the method, whether the operation was a program or an erase, the byte that was written, and a timeout limit in clock cycles. The limit is wide enough to cover a chip erase of tens of milliseconds at typical fabric clocks. The host must pulse start only after the final command strobe. That is the fourth strobe for a program and the sixth for an erase. On completion the poller pulses done, and if it timed out it pulses fail together with done. It also reports how many cycles it was busy. Issuing the command bytes and the physical bus timing are outside this block.

Top module: `flash_write_poller`

## Requirements
- R1: After reset, done, fail and rd_req are 0 and cycles is 0.
- R2: A start accepted in idle drives rd_req high in the very next cycle.
- R3: Polling method (mode_toggle=0) for a program (op_erase=0): a reply counts as complete when its bit 7 equals bit 7 of exp_data.
- R4: Polling method for an erase (op_erase=1): a reply counts as complete only when its bit 7 is 1, whatever exp_data holds.
- R5: Toggle method (mode_toggle=1): a reply counts as complete when its bit 6 equals bit 6 of the previous reply in the same run; the first reply of a run never counts.
- R6: done without fail is raised only after a complete reply is followed by two more complete replies; any reply that is not complete during the confirmation restarts the search.
- R7: At most one read is outstanding: a new rd_req follows only a rd_valid, so a run that ends after n replies issues exactly n requests.
- R8: If no success has occurred by the cycle in which the busy count equals timeout_lim, fail and done are raised together and the poller returns to idle with cycles = timeout_lim + 1.
- R9: A start pulse while busy is ignored; the captured method, operation, data and limit are unchanged.
- R10: cycles reports the number of busy cycles from the first request cycle to the cycle of the final reply or timeout, inclusive.
- R11: done and fail are single-cycle pulses; on success fail stays 0.
- R12: A reply that arrives while idle causes no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin polling (idle only) |
| mode_toggle | input | 1 | 0: complement polling on bit 7, 1: toggle detection on bit 6 |
| op_erase | input | 1 | 0: program, 1: erase |
| exp_data | input | DATA_W | Byte written by the program |
| timeout_lim | input | CNT_W | Timeout limit in cycles |
| rd_req | output | 1 | One-cycle status read request |
| rd_valid | input | 1 | Status read reply valid |
| rd_data | input | DATA_W | Status read reply byte |
| done | output | 1 | Run finished (success or timeout) |
| fail | output | 1 | Run ended by timeout |
| cycles | output | CNT_W | Busy cycles of the last run |

## Verification
The assertions take for granted that a reply arrives no earlier than the cycle after its request, that rd_valid is never high in the same cycle as rd_req, and that no reply comes without a request. The bench responder holds to this. It answers each request exactly once, after a fixed latency of at least one cycle. The one exception is a single late reply after a timeout, and that reply lands while the poller is idle. Start pulses are driven at the falling clock edge, and the only start issued during a run is the one that deliberately tests R9.

// File: rtl/poll_pkg.sv
package poll_pkg;
  typedef enum logic { M_POLL = 1'b0, M_TOGGLE = 1'b1 } method_t;
  typedef enum logic { ST_IDLE = 1'b0, ST_WAIT = 1'b1 } state_t;
  typedef enum logic [1:0] {
    PH_SEEK  = 2'd0,
    PH_CONF1 = 2'd1,
    PH_CONF2 = 2'd2
  } phase_t;
endpackage

// File: rtl/poll_judge.sv
module poll_judge #(
  parameter int DATA_W = 8
) (
  input  poll_pkg::method_t  method,
  input  logic               erase,
  input  logic               exp_hi,
  input  logic               have_prev,
  input  logic               prev_tog,
  input  logic [DATA_W-1:0]  rsp_byte,
  output logic               hit
);
  import poll_pkg::*;
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  always_comb begin
    if (method == M_TOGGLE)
      hit = have_prev && (rsp_byte[TOG_BIT] == prev_tog);
    else if (erase)
      hit = rsp_byte[POLL_BIT];
    else
      hit = (rsp_byte[POLL_BIT] == exp_hi);
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] lim_in,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      lim_q <= lim_in;
    end else if (en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt     = cnt_q;
  assign expired = en && (cnt_q == lim_q);

  // R8: while running, the count never passes the captured limit
  a_r8_count_bounded: assert property (@(posedge clk) disable iff (rst)
    en |-> (cnt_q <= lim_q));
endmodule

// File: rtl/flash_write_poller.sv
module flash_write_poller #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 22
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_toggle,
  input  logic              op_erase,
  input  logic [DATA_W-1:0] exp_data,
  input  logic [CNT_W-1:0]  timeout_lim,
  output logic              rd_req,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              fail,
  output logic [CNT_W-1:0]  cycles
);
  import poll_pkg::*;
  localparam int TOG_BIT = DATA_W - 2;

  state_t           state_q;
  phase_t           phase_q, phase_nx;
  method_t          method_q;
  logic             erase_q, exp_hi_q, have_prev_q, prev_tog_q;
  logic             req_q, done_q, fail_q;
  logic [CNT_W-1:0] cycles_q, cnt;
  logic             hit, expired, accept, busy, success;

  assign accept  = (state_q == ST_IDLE) && start;
  assign busy    = (state_q == ST_WAIT);
  assign success = busy && rd_valid && hit && (phase_q == PH_CONF2);

  poll_judge #(.DATA_W(DATA_W)) judge_i (
    .method   (method_q),
    .erase    (erase_q),
    .exp_hi   (exp_hi_q),
    .have_prev(have_prev_q),
    .prev_tog (prev_tog_q),
    .rsp_byte (rd_data),
    .hit      (hit)
  );

  poll_timer #(.CNT_W(CNT_W)) timer_i (
    .clk    (clk),
    .rst    (rst),
    .clr    (accept),
    .en     (busy),
    .lim_in (timeout_lim),
    .cnt    (cnt),
    .expired(expired)
  );

  always_comb begin
    phase_nx = PH_SEEK;
    if (hit) begin
      case (phase_q)
        PH_SEEK:  phase_nx = PH_CONF1;
        PH_CONF1: phase_nx = PH_CONF2;
        default:  phase_nx = PH_SEEK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      phase_q     <= PH_SEEK;
      method_q    <= M_POLL;
      erase_q     <= 1'b0;
      exp_hi_q    <= 1'b0;
      have_prev_q <= 1'b0;
      prev_tog_q  <= 1'b0;
      req_q       <= 1'b0;
      done_q      <= 1'b0;
      fail_q      <= 1'b0;
      cycles_q    <= '0;
    end else begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            method_q    <= method_t'(mode_toggle);
            erase_q     <= op_erase;
            exp_hi_q    <= exp_data[DATA_W-1];
            have_prev_q <= 1'b0;
            phase_q     <= PH_SEEK;
            req_q       <= 1'b1;
            state_q     <= ST_WAIT;
          end
        end
        default: begin
          if (success) begin
            done_q   <= 1'b1;
            cycles_q <= cnt + 1'b1;
            state_q  <= ST_IDLE;
          end else if (expired) begin
            done_q   <= 1'b1;
            fail_q   <= 1'b1;
            cycles_q <= cnt + 1'b1;
            state_q  <= ST_IDLE;
          end else if (rd_valid) begin
            phase_q     <= phase_nx;
            prev_tog_q  <= rd_data[TOG_BIT];
            have_prev_q <= 1'b1;
            req_q       <= 1'b1;
          end
        end
      endcase
    end
  end

  assign rd_req = req_q;
  assign done   = done_q;
  assign fail   = fail_q;
  assign cycles = cycles_q;

  // R2: accepted start is followed by a request
  a_r2_req_follows_start: assert property (@(posedge clk) disable iff (rst)
    accept |=> rd_req);
  // R7: a request is never directly followed by another
  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R8: fail only ever comes with done
  a_r8_fail_implies_done: assert property (@(posedge clk) disable iff (rst)
    fail |-> done);
  // R11: done lasts one cycle
  a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R6: a success is always caused by a reply
  a_r6_success_on_reply: assert property (@(posedge clk) disable iff (rst)
    (done && !fail) |-> $past(rd_valid));
  // R12: a reply in idle triggers nothing
  a_r12_idle_ignores_reply: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start && rd_valid) |=> (!rd_req && !done));
endmodule

// File: tb/flash_write_poller_tb_top.sv
module flash_write_poller_tb_top;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 22;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              mode_toggle = 1'b0;
  logic              op_erase = 1'b0;
  logic [DATA_W-1:0] exp_data = '0;
  logic [CNT_W-1:0]  timeout_lim = '0;
  logic              rd_req;
  logic              rd_valid = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic              done, fail;
  logic [CNT_W-1:0]  cycles;

  int checks = 0;
  int errors = 0;
  int req_cnt = 0;
  int lat = 1;
  logic [DATA_W-1:0] resp_q[$];
  bit    expf_q[$];
  int    expc_q[$];
  string tag_q[$];
  bit    finished = 0;

  always #4 clk = ~clk;

  flash_write_poller #(.DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .mode_toggle(mode_toggle),
    .op_erase(op_erase), .exp_data(exp_data), .timeout_lim(timeout_lim),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .fail(fail), .cycles(cycles)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Responder: one reply per request after lat cycles
  initial begin
    forever begin
      @(negedge clk);
      while (rd_req) begin
        req_cnt++;
        repeat (lat) @(negedge clk);
        rd_valid = 1'b1;
        rd_data  = (resp_q.size() != 0) ? resp_q.pop_front() : '0;
        @(negedge clk);
        rd_valid = 1'b0;
      end
    end
  end

  // Monitor: pops expected results as done pulses appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (expf_q.size() == 0) begin
          check(1'b0, "R12", "unexpected done", 1, 0);
        end else begin
          automatic bit    ef = expf_q.pop_front();
          automatic int    ec = expc_q.pop_front();
          automatic string tg = tag_q.pop_front();
          check(fail == ef, ef ? "R8" : "R11", {tg, " fail flag"}, fail, ef);
          check(cycles == CNT_W'(ec), "R10", {tg, " cycles"}, cycles, ec);
          @(negedge clk);
          check(!done && !fail, "R11", {tg, " pulse width"}, done, 0);
        end
      end
    end
  end

  task automatic run_case(input string tg, input bit tog, input bit ers,
                          input logic [7:0] ed, input int lim, input int l,
                          input bit ef, input int ec, input int ereqs,
                          input int poke_at);
    lat = l;
    req_cnt = 0;
    expf_q.push_back(ef);
    expc_q.push_back(ec);
    tag_q.push_back(tg);
    @(negedge clk);
    start = 1'b1; mode_toggle = tog; op_erase = ers;
    exp_data = ed; timeout_lim = CNT_W'(lim);
    @(negedge clk);
    start = 1'b0;
    check(rd_req == 1'b1, "R2", {tg, " request after start"}, rd_req, 1);
    if (poke_at > 0) begin
      repeat (poke_at) @(negedge clk);
      // R9: a start during the run with different settings
      start = 1'b1; mode_toggle = 1'b0; op_erase = 1'b1;
      exp_data = 8'hFF; timeout_lim = CNT_W'(5);
      @(negedge clk);
      start = 1'b0;
    end
    while (expf_q.size() != 0) @(negedge clk);
    repeat (l + 6) @(negedge clk);
    check(req_cnt == ereqs, "R7", {tg, " request count"}, req_cnt, ereqs);
    resp_q.delete();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !fail && !rd_req && cycles == '0, "R1", "reset state",
          {done, fail, rd_req}, 0);

    // R3: program, expected bit7=1; complement 0 first
    resp_q = {8'h25, 8'h25, 8'hA5, 8'hA5, 8'hA5};
    run_case("R3 prog hi", 0, 0, 8'hA5, 1000, 1, 0, 10, 5, 0);
    // R3: program, expected bit7=0, latency 2
    resp_q = {8'h80, 8'h3C, 8'h3C, 8'h3C};
    run_case("R3 prog lo", 0, 0, 8'h3C, 1000, 2, 0, 12, 4, 0);
    // R4: erase ignores exp_data; bit7=0 is busy
    resp_q = {8'h00, 8'h80, 8'h80, 8'h80};
    run_case("R4 erase", 0, 1, 8'h00, 1000, 1, 0, 8, 4, 0);
    // R5: toggle, first reply never counts
    resp_q = {8'h40, 8'h00, 8'h40, 8'h40, 8'h40, 8'h40};
    run_case("R5 toggle", 1, 0, 8'h00, 1000, 1, 0, 12, 6, 0);
    // R6: polling confirmation broken twice
    resp_q = {8'h80, 8'h00, 8'h80, 8'h80, 8'h00, 8'h80, 8'h80, 8'h80};
    run_case("R6 poll confirm", 0, 0, 8'h80, 1000, 1, 0, 16, 8, 0);
    // R6: toggle confirmation broken by a change
    resp_q = {8'h40, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00};
    run_case("R6 toggle confirm", 1, 0, 8'h00, 1000, 1, 0, 12, 6, 0);
    // R9: start while busy must not switch to erase or a short limit
    resp_q = {8'h80, 8'h80, 8'h80, 8'h00, 8'h00, 8'h00};
    run_case("R9 busy start", 0, 0, 8'h00, 1000, 1, 0, 12, 6, 3);
    // R8: timeout; the 11th reply arrives in idle (R12)
    run_case("R8 timeout", 0, 0, 8'h80, 20, 1, 1, 21, 11, 0);
    check(!done && !rd_req, "R12", "quiet after late reply", done, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule